// File: doc/BRIEF.md
# UART Host Register Bus Slave

This block is the processor-facing side of a UART register file. A bus cycle has two phases. First, an active-low address strobe captures the register offset and the chip select. Then, after the host has released the address lines, an active-low write strobe or read strobe moves data into or out of the slot chosen by the latched offset. All strobes are synchronous to the internal clock, and each phase lasts at least one clock period.

The block decodes eight register slots:

- Three writable slots hold plain storage: interrupt enable, line control and modem control.
- Offset 0 is shared. A write sends a character to the transmitter with a one-cycle strobe. A read returns the receive buffer byte, and the strobe's rising edge sends a one-cycle acknowledge back to the receiver.
- The interrupt identification, line status and modem status slots are supplied by neighbouring logic. They are read-only.
- Offset 7 reads as zero.

The block also produces a per-slot write-enable vector and a driver-disable output. The driver-disable output tells the pad logic when to turn the data bus around.

Top module: `uart_host_bus`

## Requirements
- R1: The offset and select are sampled on every clock edge that sees the address strobe low. They are held unchanged while the strobe is high, so the address lines may be driven to all ones and the select dropped before the data strobe without effect.
- R2: A write takes effect on the rising edge of the write strobe. It uses the data present in the last clock cycle in which the strobe was still low, so data may arrive after the strobe falls. The new contents are visible two clock edges after the strobe rises.
- R3: Writable slots are at offset 1 (interrupt enable), 3 (line control) and 4 (modem control). Their stored value appears on the matching output and reads back at the same offset.
- R4: A write to offset 0 places the byte on the transmit data output and raises the transmit strobe for exactly one cycle.
- R5: While the read strobe is low on a selected cycle, the read data output carries the slot contents from the second clock edge after the falling edge. Offset 0 returns the receive byte input, 2 the interrupt identification input, 5 the line status input, 6 the modem status input, and 7 returns zero.
- R6: The read data output is zero whenever the previous cycle was not a selected read.
- R7: The driver-disable output is low only from the first clock edge after a selected read strobe falls until the first edge after it rises. It is high at all other times.
- R8: Releasing the read strobe on a selected read of offset 0 produces exactly one acknowledge cycle. Reads of other offsets produce none.
- R9: Writes to offsets 2, 5, 6 and 7 change no stored slot, the transmit output and strobe, or any write-enable bit.
- R10: A cycle whose latched select is low writes nothing, acknowledges nothing, keeps the driver-disable output high and returns zero read data.
- R11: The write-enable vector (bit n = offset n) pulses one bit for one cycle per write to offsets 0, 1, 3 or 4. It is otherwise all zero.
- R12: A synchronous active-high reset clears the latched offset and select, all writable slots and the transmit output. The driver-disable output then reads high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal clock |
| rst | input | 1 | Synchronous active-high master reset |
| cs_i | input | 1 | Chip select, sampled during the address phase |
| as_n_i | input | 1 | Address strobe, active low |
| addr_i | input | 3 | Register offset |
| wr_n_i | input | 1 | Write strobe, active low |
| rd_n_i | input | 1 | Read strobe, active low |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data |
| drv_dis_o | output | 1 | High except during a selected read |
| rx_byte_i | input | 8 | Receive buffer byte from the receiver |
| irq_id_i | input | 8 | Interrupt identification value |
| line_stat_i | input | 8 | Line status value |
| modem_stat_i | input | 8 | Modem status value |
| tx_byte_o | output | 8 | Last byte written to offset 0 |
| tx_load_o | output | 1 | One-cycle transmit strobe |
| rx_ack_o | output | 1 | One-cycle receive acknowledge |
| irq_en_o | output | 8 | Interrupt enable slot |
| line_ctl_o | output | 8 | Line control slot |
| modem_ctl_o | output | 8 | Modem control slot |
| slot_we_o | output | 8 | Per-slot write enables |

## Verification
Every bus cycle releases the address lines to all ones and drops the select before the data strobe. A design that tracked the live address would then write or read offset 7 instead of the latched slot.

Write data is driven only one cycle after the write strobe falls. A design that captured data on the falling edge, or after the rising edge, stores a stale or idle byte.

Random cycles mix deselected addresses, writes to read-only offsets and reads of every slot. A decoder that leaks enables shows up as a changed slot or a spurious write-enable or acknowledge count. Receive acknowledges are counted per read, so a level instead of a pulse, or an acknowledge on the wrong offset, is reported.

A mid-run reset checks that stored slots return to zero.

// File: rtl/uart_hbus_pkg.sv
package uart_hbus_pkg;

    localparam int SLOT_W    = 3;
    localparam int NUM_SLOTS = 1 << SLOT_W;

    typedef enum logic [SLOT_W-1:0] {
        SLOT_DATA  = 3'd0,
        SLOT_IEN   = 3'd1,
        SLOT_IID   = 3'd2,
        SLOT_LCTL  = 3'd3,
        SLOT_MCTL  = 3'd4,
        SLOT_LSTAT = 3'd5,
        SLOT_MSTAT = 3'd6,
        SLOT_NONE  = 3'd7
    } slot_e;

    typedef struct packed {
        logic  sel;
        slot_e slot;
    } bus_addr_t;

    function automatic logic slot_writable(slot_e s);
        return (s == SLOT_DATA) || (s == SLOT_IEN) ||
               (s == SLOT_LCTL) || (s == SLOT_MCTL);
    endfunction

    function automatic logic [NUM_SLOTS-1:0] slot_write_vec(slot_e s);
        logic [NUM_SLOTS-1:0] v;
        v = '0;
        if (slot_writable(s)) v[s] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/hbus_strobe_sync.sv
module hbus_strobe_sync #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] strb_n_i,
    output logic [N-1:0] act_o,
    output logic [N-1:0] rise_o
);
    logic [N-1:0] s1_q, s2_q;

    for (genvar i = 0; i < N; i++) begin : g_strb
        always_ff @(posedge clk) begin
            if (rst) begin
                s1_q[i] <= 1'b1;
                s2_q[i] <= 1'b1;
            end else begin
                s1_q[i] <= strb_n_i[i];
                s2_q[i] <= s1_q[i];
            end
        end
        assign act_o[i]  = ~s1_q[i];
        assign rise_o[i] = s1_q[i] & ~s2_q[i];

        // R2
        rise_single_chk: assert property (@(posedge clk) disable iff (rst)
            rise_o[i] |=> !rise_o[i]);
    end
endmodule

// File: rtl/hbus_addr_latch.sv
module hbus_addr_latch
    import uart_hbus_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              as_n_i,
    input  logic              cs_i,
    input  logic [SLOT_W-1:0] addr_i,
    output bus_addr_t         lat_o
);
    bus_addr_t lat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lat_q <= '{sel: 1'b0, slot: SLOT_DATA};
        end else if (!as_n_i) begin
            lat_q.sel  <= cs_i;
            lat_q.slot <= slot_e'(addr_i);
        end
    end

    assign lat_o = lat_q;

    // R1
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        as_n_i |=> $stable(lat_q));
endmodule

// File: rtl/hbus_reg_file.sv
module hbus_reg_file
    import uart_hbus_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_SLOTS-1:0] we_i,
    input  logic [DATA_W-1:0]    wdata_i,
    input  slot_e                rslot_i,
    input  logic [DATA_W-1:0]    rx_byte_i,
    input  logic [DATA_W-1:0]    irq_id_i,
    input  logic [DATA_W-1:0]    line_stat_i,
    input  logic [DATA_W-1:0]    modem_stat_i,
    output logic [DATA_W-1:0]    tx_byte_o,
    output logic [DATA_W-1:0]    irq_en_o,
    output logic [DATA_W-1:0]    line_ctl_o,
    output logic [DATA_W-1:0]    modem_ctl_o,
    output logic [DATA_W-1:0]    rmux_o
);
    typedef struct packed {
        logic [DATA_W-1:0] tx;
        logic [DATA_W-1:0] ien;
        logic [DATA_W-1:0] lctl;
        logic [DATA_W-1:0] mctl;
    } store_t;

    store_t st_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            if (we_i[SLOT_DATA]) st_q.tx   <= wdata_i;
            if (we_i[SLOT_IEN])  st_q.ien  <= wdata_i;
            if (we_i[SLOT_LCTL]) st_q.lctl <= wdata_i;
            if (we_i[SLOT_MCTL]) st_q.mctl <= wdata_i;
        end
    end

    always_comb begin
        unique case (rslot_i)
            SLOT_DATA:  rmux_o = rx_byte_i;
            SLOT_IEN:   rmux_o = st_q.ien;
            SLOT_IID:   rmux_o = irq_id_i;
            SLOT_LCTL:  rmux_o = st_q.lctl;
            SLOT_MCTL:  rmux_o = st_q.mctl;
            SLOT_LSTAT: rmux_o = line_stat_i;
            SLOT_MSTAT: rmux_o = modem_stat_i;
            default:    rmux_o = '0;
        endcase
    end

    assign tx_byte_o   = st_q.tx;
    assign irq_en_o    = st_q.ien;
    assign line_ctl_o  = st_q.lctl;
    assign modem_ctl_o = st_q.mctl;

    // R11
    we_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(we_i));
    // R9
    ien_keep_chk: assert property (@(posedge clk) disable iff (rst)
        !we_i[SLOT_IEN] |=> $stable(st_q.ien));
    // R9
    lctl_keep_chk: assert property (@(posedge clk) disable iff (rst)
        !we_i[SLOT_LCTL] |=> $stable(st_q.lctl));
endmodule

// File: rtl/uart_host_bus.sv
module uart_host_bus
    import uart_hbus_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cs_i,
    input  logic                 as_n_i,
    input  logic [SLOT_W-1:0]    addr_i,
    input  logic                 wr_n_i,
    input  logic                 rd_n_i,
    input  logic [DATA_W-1:0]    wdata_i,
    output logic [DATA_W-1:0]    rdata_o,
    output logic                 drv_dis_o,
    input  logic [DATA_W-1:0]    rx_byte_i,
    input  logic [DATA_W-1:0]    irq_id_i,
    input  logic [DATA_W-1:0]    line_stat_i,
    input  logic [DATA_W-1:0]    modem_stat_i,
    output logic [DATA_W-1:0]    tx_byte_o,
    output logic                 tx_load_o,
    output logic                 rx_ack_o,
    output logic [DATA_W-1:0]    irq_en_o,
    output logic [DATA_W-1:0]    line_ctl_o,
    output logic [DATA_W-1:0]    modem_ctl_o,
    output logic [NUM_SLOTS-1:0] slot_we_o
);
    localparam int STRB_RD = 0;
    localparam int STRB_WR = 1;

    logic [1:0]           act, rise;
    bus_addr_t            lat;
    logic [DATA_W-1:0]    wr_hold_q;
    logic [DATA_W-1:0]    rmux;
    logic [DATA_W-1:0]    rdata_q;
    logic [NUM_SLOTS-1:0] we;
    logic                 rd_sel;

    hbus_strobe_sync #(.N(2)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .strb_n_i ({wr_n_i, rd_n_i}),
        .act_o    (act),
        .rise_o   (rise)
    );

    hbus_addr_latch u_alat (
        .clk    (clk),
        .rst    (rst),
        .as_n_i (as_n_i),
        .cs_i   (cs_i),
        .addr_i (addr_i),
        .lat_o  (lat)
    );

    // Holds the byte seen in the last cycle the write strobe was low.
    always_ff @(posedge clk) begin
        if (rst)          wr_hold_q <= '0;
        else if (!wr_n_i) wr_hold_q <= wdata_i;
    end

    assign we = (rise[STRB_WR] && lat.sel) ? slot_write_vec(lat.slot) : '0;

    hbus_reg_file #(.DATA_W(DATA_W)) u_regs (
        .clk          (clk),
        .rst          (rst),
        .we_i         (we),
        .wdata_i      (wr_hold_q),
        .rslot_i      (lat.slot),
        .rx_byte_i    (rx_byte_i),
        .irq_id_i     (irq_id_i),
        .line_stat_i  (line_stat_i),
        .modem_stat_i (modem_stat_i),
        .tx_byte_o    (tx_byte_o),
        .irq_en_o     (irq_en_o),
        .line_ctl_o   (line_ctl_o),
        .modem_ctl_o  (modem_ctl_o),
        .rmux_o       (rmux)
    );

    assign rd_sel = act[STRB_RD] && lat.sel;

    always_ff @(posedge clk) begin
        if (rst) rdata_q <= '0;
        else     rdata_q <= rd_sel ? rmux : '0;
    end

    assign rdata_o   = rdata_q;
    assign drv_dis_o = ~rd_sel;
    assign rx_ack_o  = rise[STRB_RD] && lat.sel && (lat.slot == SLOT_DATA);
    assign tx_load_o = we[SLOT_DATA];
    assign slot_we_o = we;

    // R6
    rdata_idle_chk: assert property (@(posedge clk) disable iff (rst)
        drv_dis_o |=> rdata_o == '0);
    // R8
    ack_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rx_ack_o |=> !rx_ack_o);
    // R4
    tx_load_chk: assert property (@(posedge clk) disable iff (rst)
        tx_load_o |=> tx_byte_o == $past(wr_hold_q));
    // R10
    nosel_chk: assert property (@(posedge clk) disable iff (rst)
        !lat.sel |-> (slot_we_o == '0) && !rx_ack_o);
endmodule

// File: tb/uart_host_bus_bench.sv
module uart_host_bus_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_i = 1'b0, as_n_i = 1'b1, wr_n_i = 1'b1, rd_n_i = 1'b1;
    logic [2:0] addr_i = 3'd7;
    logic [7:0] wdata_i = 8'hff;
    logic [7:0] rdata_o, tx_byte_o, irq_en_o, line_ctl_o, modem_ctl_o, slot_we_o;
    logic       drv_dis_o, tx_load_o, rx_ack_o;
    logic [7:0] rx_byte_i = 8'h00, irq_id_i = 8'h01, line_stat_i = 8'h60, modem_stat_i = 8'h00;

    int n_vec = 0, n_bad = 0;
    int ack_cnt = 0, load_cnt = 0;
    int we_cnt [8];
    logic [7:0] m_ien = 0, m_lctl = 0, m_mctl = 0, m_tx = 0;

    always #5 clk = ~clk;

    uart_host_bus u_uart_host_bus (
        .clk(clk), .rst(rst), .cs_i(cs_i), .as_n_i(as_n_i), .addr_i(addr_i),
        .wr_n_i(wr_n_i), .rd_n_i(rd_n_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
        .drv_dis_o(drv_dis_o), .rx_byte_i(rx_byte_i), .irq_id_i(irq_id_i),
        .line_stat_i(line_stat_i), .modem_stat_i(modem_stat_i),
        .tx_byte_o(tx_byte_o), .tx_load_o(tx_load_o), .rx_ack_o(rx_ack_o),
        .irq_en_o(irq_en_o), .line_ctl_o(line_ctl_o), .modem_ctl_o(modem_ctl_o),
        .slot_we_o(slot_we_o)
    );

    initial foreach (we_cnt[i]) we_cnt[i] = 0;

    always @(negedge clk) begin
        if (!rst) begin
            if (rx_ack_o)  ack_cnt++;
            if (tx_load_o) load_cnt++;
            for (int i = 0; i < 8; i++) if (slot_we_o[i]) we_cnt[i]++;
        end
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_read(logic [2:0] a);
        case (a)
            3'd0: return rx_byte_i;
            3'd1: return m_ien;
            3'd2: return irq_id_i;
            3'd3: return m_lctl;
            3'd4: return m_mctl;
            3'd5: return line_stat_i;
            3'd6: return modem_stat_i;
            default: return 8'h00;
        endcase
    endfunction

    function automatic bit writable(logic [2:0] a);
        return a == 0 || a == 1 || a == 3 || a == 4;
    endfunction

    task automatic addr_phase(logic [2:0] a, logic c);
        @(negedge clk); as_n_i = 1'b0; cs_i = c; addr_i = a;
        @(negedge clk); as_n_i = 1'b1;
        @(negedge clk); addr_i = 3'd7; cs_i = 1'b0;
    endtask

    task automatic bus_write(logic [2:0] a, logic [7:0] d, logic c);
        int we0 [8];
        int ld0;
        foreach (we0[i]) we0[i] = we_cnt[i];
        ld0 = load_cnt;
        addr_phase(a, c);
        @(negedge clk); wr_n_i = 1'b0;
        @(negedge clk); wdata_i = d;
        @(negedge clk); wr_n_i = 1'b1;
        @(negedge clk); wdata_i = 8'hff;
        repeat (2) @(negedge clk);
        if (c && writable(a)) begin
            case (a)
                3'd0: m_tx   = d;
                3'd1: m_ien  = d;
                3'd3: m_lctl = d;
                3'd4: m_mctl = d;
                default: ;
            endcase
        end
        for (int i = 0; i < 8; i++)
            check("R11 we count", we_cnt[i] - we0[i],
                  (c && writable(a) && i == a) ? 1 : 0);
        check("R4 tx load", load_cnt - ld0, (c && a == 0) ? 1 : 0);
        check("R4 tx byte", tx_byte_o, m_tx);
        check("R3 ien", irq_en_o, m_ien);
        check("R3 lctl", line_ctl_o, m_lctl);
        check("R9 mctl", modem_ctl_o, m_mctl);
    endtask

    task automatic bus_read(logic [2:0] a, logic c);
        logic [7:0] got, exp;
        logic       dis;
        int         a0;
        a0 = ack_cnt;
        addr_phase(a, c);
        check("R7 dis idle", drv_dis_o, 1);
        @(negedge clk); rd_n_i = 1'b0;
        @(negedge clk);
        check("R7 dis early", drv_dis_o, c ? 0 : 1);
        @(negedge clk);
        got = rdata_o; dis = drv_dis_o;
        exp = c ? exp_read(a) : 8'h00;
        rd_n_i = 1'b1;
        repeat (3) @(negedge clk);
        check(c ? "R5 read data" : "R10 desel data", got, exp);
        check(c ? "R7 dis read" : "R10 desel dis", dis, c ? 0 : 1);
        check("R8 ack count", ack_cnt - a0, (c && a == 0) ? 1 : 0);
        check("R6 rdata idle", rdata_o, 0);
        check("R7 dis after", drv_dis_o, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12 reset state
        check("R12 ien", irq_en_o, 0);
        check("R12 lctl", line_ctl_o, 0);
        check("R12 mctl", modem_ctl_o, 0);
        check("R12 tx", tx_byte_o, 0);
        check("R12 dis", drv_dis_o, 1);
        check("R12 rdata", rdata_o, 0);

        // R1 R2 R3: late data, released address
        bus_write(3'd1, 8'h5a, 1'b1);
        bus_write(3'd3, 8'h1b, 1'b1);
        bus_write(3'd4, 8'h03, 1'b1);
        bus_write(3'd0, 8'hc3, 1'b1);
        bus_read(3'd1, 1'b1);
        bus_read(3'd3, 1'b1);
        bus_read(3'd4, 1'b1);
        // R9 read-only and empty slots ignore writes
        bus_write(3'd2, 8'hee, 1'b1);
        bus_write(3'd5, 8'hdd, 1'b1);
        bus_write(3'd6, 8'hcc, 1'b1);
        bus_write(3'd7, 8'hbb, 1'b1);
        // R5 status reads, R8 ack on offset 0
        rx_byte_i = 8'ha7; modem_stat_i = 8'hb0;
        for (int a = 0; a < 8; a++) bus_read(3'(a), 1'b1);
        // R10 deselected cycles
        bus_write(3'd1, 8'h99, 1'b0);
        bus_read(3'd0, 1'b0);

        for (int k = 0; k < 200; k++) begin
            logic [2:0] a;
            logic       c;
            a = 3'($urandom_range(0, 7));
            c = ($urandom_range(0, 7) != 0);
            rx_byte_i    = 8'($urandom);
            irq_id_i     = 8'($urandom);
            line_stat_i  = 8'($urandom);
            modem_stat_i = 8'($urandom);
            if ($urandom_range(0, 1) == 0) bus_write(a, 8'($urandom), c);
            else                           bus_read(a, c);
        end

        // R12 reset mid-run clears slots
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        m_ien = 0; m_lctl = 0; m_mctl = 0; m_tx = 0;
        check("R12 ien clr", irq_en_o, 0);
        check("R12 lctl clr", line_ctl_o, 0);
        check("R12 mctl clr", modem_ctl_o, 0);
        check("R12 tx clr", tx_byte_o, 0);
        bus_read(3'd3, 1'b1);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule